// File: doc/BRIEF.md
# Signal capture and FFT sequencing controller

This block is the control core of a passive signal collection pipeline. It watches a stream of signed 8-bit samples qualified by a valid strobe. A segment opens when a sample's magnitude rises above a threshold that can be changed at run time. The block then gathers that sample and the next fifteen valid samples into a 16-entry segment buffer. The FFT engine reads the segment through a dedicated read port.

Once the segment is complete, the controller pulses a start request to the FFT engine and waits for the engine's done flag. It then reads the sixteen result bins out of the engine's synchronous output port. It writes each bin into a storage memory two cycles after issuing its read address, so that the write address and the returned data arrive together. A write pointer carries on across segments, so no storage location is ever written twice. When fewer than one segment of free space remains, the controller parks in a full state and ignores further activity. Debug outputs expose the state code and the write pointer.

Top module: `capture_seq_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block resets to state code 0 (idle): dbg_state_o = 0, dbg_wptr_o = 0, and full_o, fft_start_o, res_rd_o and mem_we_o are all 0.
- R2: In state 0, a sample with smp_vld_i = 1 whose two's-complement magnitude is strictly greater than the unsigned thr_i is stored as buffer entry 0, and the state becomes 1 (fill). The magnitude of -128 is 128. A sample with a smaller or equal magnitude, or one without the strobe, leaves the state at 0.
- R3: In state 1, each sample with smp_vld_i = 1 is stored at the next buffer index in arrival order, and cycles without the strobe store nothing. After the 16th stored sample the state becomes 2. Entry k appears on buf_rdata_o one cycle after buf_raddr_i = k.
- R4: In state 2, fft_start_o is 1 for exactly one cycle, and the state then becomes 3 (wait).
- R5: The state stays 3 until fft_done_i = 1 and then becomes 4 (store). Samples that arrive in any state other than 0 and 1 do not change the buffer.
- R6: In state 4, the block raises res_rd_o on 16 consecutive cycles with res_addr_o = 0, 1, ..., 15. mem_we_o rises exactly 2 cycles after each of these reads, with mem_data_o equal to res_data_i in that cycle.
- R7: Every write goes to mem_addr_o = the write pointer, which then increases by 1. Only a reset lowers the pointer, so segment n is written to addresses 16n to 16n+15.
- R8: After the last bin has been read, the state is 5 (drain) until the final write has landed. The state then becomes 0 if at least 16 storage locations are still free, and otherwise 6 (full). In state 6, full_o = 1, the state stays 6, no write occurs and incoming samples are ignored.
- R9: dbg_state_o shows the state code above, and dbg_wptr_o shows the number of writes made since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_i | input | 8 | Signed input sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| thr_i | input | 8 | Unsigned activity threshold on sample magnitude |
| buf_raddr_i | input | 4 | Segment buffer read index from the FFT engine |
| buf_rdata_o | output | 8 | Segment buffer read data, one cycle after the index |
| fft_start_o | output | 1 | One-cycle start request to the FFT engine |
| fft_done_i | input | 1 | FFT completion flag |
| res_rd_o | output | 1 | Read request to the FFT result port |
| res_addr_o | output | 4 | Result bin index being read |
| res_data_i | input | 32 | Result bin data, valid two cycles after the read |
| mem_we_o | output | 1 | Storage memory write enable |
| mem_addr_o | output | 6 | Storage memory write address |
| mem_data_o | output | 32 | Storage memory write data |
| full_o | output | 1 | Storage exhausted; new segments refused |
| dbg_state_o | output | 3 | Current state code |
| dbg_wptr_o | output | 7 | Current write pointer |

## Verification
A qualifying sample, each 16th fill sample and the done flag each move the state on the next clock edge, and fft_start_o follows from the state in that same cycle. The bench drives inputs on falling edges and reads dbg_state_o and fft_start_o at the very next falling edge. A write to storage is due exactly two cycles after its bin read. The bench's FFT result model returns the tagged bin data only in that cycle and a poison word at all other times, so any write that comes early or late carries wrong data and is flagged at the write itself. Buffer reads are checked one falling edge after the index is driven, which matches the one-cycle read latency.

// File: rtl/cap_pkg.sv
// Package: shared state encoding for the capture sequencing controller.
// Assumes: codes are exported on a debug port, so their values are fixed.
package cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_TRIG  = 3'd2,
        ST_WAIT  = 3'd3,
        ST_STORE = 3'd4,
        ST_DRAIN = 3'd5,
        ST_FULL  = 3'd6
    } cap_state_e;

endpackage

// File: rtl/cap_activity_det.sv
// Module: activity detector. Flags a valid sample whose magnitude exceeds
// an unsigned threshold.
// Assumes: samples are two's complement; the most negative value has a
// magnitude of 2**(SMP_W-1), and that magnitude fits in SMP_W unsigned bits.
module cap_activity_det #(
    parameter int SMP_W = 8
) (
    input  logic [SMP_W-1:0] smp_i,
    input  logic             vld_i,
    input  logic [SMP_W-1:0] thr_i,
    output logic             hit_o
);

    logic [SMP_W-1:0] mag;

    // Magnitude of the sample, then the strict comparison against the threshold.
    always_comb begin
        mag   = smp_i[SMP_W-1] ? (~smp_i + 1'b1) : smp_i;
        hit_o = vld_i && (mag > thr_i);
    end

endmodule

// File: rtl/cap_seg_buffer.sv
// Module: segment buffer. SEG_LEN entries with one write port and one
// registered read port.
// Assumes: a write and a read to the same entry in one cycle return the
// old value.
module cap_seg_buffer #(
    parameter int SMP_W   = 8,
    parameter int SEG_LEN = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [$clog2(SEG_LEN)-1:0] waddr_i,
    input  logic [SMP_W-1:0]           wdata_i,
    input  logic [$clog2(SEG_LEN)-1:0] raddr_i,
    output logic [SMP_W-1:0]           rdata_o
);

    localparam int IDX_W = $clog2(SEG_LEN);

    logic [SMP_W-1:0] mem_q [SEG_LEN];

    // One write-enabled register per entry.
    for (genvar i = 0; i < SEG_LEN; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (we_i && (waddr_i == IDX_W'(i))) begin
                mem_q[i] <= wdata_i;
            end
        end
    end

    // Registered read: the data follows the index by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else begin
            rdata_o <= mem_q[raddr_i];
        end
    end

endmodule

// File: rtl/cap_store_seq.sv
// Module: result store sequencer. Issues SEG_LEN result reads, delays each
// one by RD_LAT cycles into a storage write, and keeps the write pointer,
// which never wraps.
// Assumes: SEG_LEN is a power of two; DEPTH >= SEG_LEN; RD_LAT >= 1; start_i
// arrives only while the sequencer is not busy.
module cap_store_seq #(
    parameter int SEG_LEN = 16,
    parameter int DEPTH   = 64,
    parameter int RD_LAT  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    output logic                       res_rd_o,
    output logic [$clog2(SEG_LEN)-1:0] res_addr_o,
    output logic                       last_issue_o,
    output logic                       busy_o,
    output logic                       mem_we_o,
    output logic [$clog2(DEPTH)-1:0]   mem_addr_o,
    output logic [$clog2(DEPTH):0]     wptr_o,
    output logic                       room_o
);

    localparam int IDX_W = $clog2(SEG_LEN);
    localparam int AW    = $clog2(DEPTH);
    localparam int LIMIT = DEPTH - SEG_LEN;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEG_LEN - 1);

    logic              issuing_q;
    logic [IDX_W-1:0]  idx_q;
    logic [RD_LAT-1:0] pipe_q;
    logic [AW:0]       wptr_q;

    // Read issue: SEG_LEN consecutive bin reads after each start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issuing_q <= 1'b0;
            idx_q     <= '0;
        end else if (start_i) begin
            issuing_q <= 1'b1;
            idx_q     <= '0;
        end else if (issuing_q) begin
            if (idx_q == LAST_IDX) begin
                issuing_q <= 1'b0;
            end
            idx_q <= idx_q + 1'b1;
        end
    end

    // Latency line: each issued read turns into a write RD_LAT cycles later.
    if (RD_LAT == 1) begin : g_lat_one
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= issuing_q;
            end
        end
    end else begin : g_lat_many
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe_q <= '0;
            end else begin
                pipe_q <= {pipe_q[RD_LAT-2:0], issuing_q};
            end
        end
    end

    // Write pointer: advances once per write and is cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
        end else if (mem_we_o) begin
            wptr_q <= wptr_q + 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        res_rd_o     = issuing_q;
        res_addr_o   = idx_q;
        last_issue_o = issuing_q && (idx_q == LAST_IDX);
        mem_we_o     = pipe_q[RD_LAT-1];
        busy_o       = issuing_q || (|pipe_q);
        mem_addr_o   = wptr_q[AW-1:0];
        wptr_o       = wptr_q;
        room_o       = (int'(wptr_q) <= LIMIT);
    end

    // R6: a bin read is followed by a write exactly two cycles later.
    p_write_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_rd_o |=> ##1 mem_we_o);

    // R6: no write appears without a read two cycles earlier.
    p_write_has_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> $past(res_rd_o, 2));

    // R7: each write advances the pointer by exactly one.
    p_ptr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> (wptr_q == $past(wptr_q) + 1'b1));

    // R7: without a write the pointer holds.
    p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_o |=> $stable(wptr_q));

    // R7: the pointer never runs past the end of storage.
    p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wptr_q <= (AW+1)'(DEPTH));

endmodule

// File: rtl/capture_seq_ctrl.sv
// Module: capture and FFT sequencing controller (top). Gates capture on
// sample activity, fills one segment, starts the FFT, waits for its done
// flag, then stores the bins through the store sequencer.
// Assumes: the FFT engine reads the buffer only between start and done;
// its result port returns data RD_LAT cycles after the read.
module capture_seq_ctrl #(
    parameter int SMP_W   = 8,
    parameter int SEG_LEN = 16,
    parameter int BIN_W   = 32,
    parameter int DEPTH   = 64,
    parameter int RD_LAT  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SMP_W-1:0]           smp_i,
    input  logic                       smp_vld_i,
    input  logic [SMP_W-1:0]           thr_i,
    input  logic [$clog2(SEG_LEN)-1:0] buf_raddr_i,
    output logic [SMP_W-1:0]           buf_rdata_o,
    output logic                       fft_start_o,
    input  logic                       fft_done_i,
    output logic                       res_rd_o,
    output logic [$clog2(SEG_LEN)-1:0] res_addr_o,
    input  logic [BIN_W-1:0]           res_data_i,
    output logic                       mem_we_o,
    output logic [$clog2(DEPTH)-1:0]   mem_addr_o,
    output logic [BIN_W-1:0]           mem_data_o,
    output logic                       full_o,
    output logic [2:0]                 dbg_state_o,
    output logic [$clog2(DEPTH):0]     dbg_wptr_o
);

    import cap_pkg::*;

    localparam int IDX_W = $clog2(SEG_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEG_LEN - 1);

    cap_state_e       state_q, state_d;
    logic [IDX_W-1:0] fill_idx_q;
    logic             hit;
    logic             buf_we;
    logic [IDX_W-1:0] buf_waddr;
    logic             store_start;
    logic             last_issue;
    logic             store_busy;
    logic             room;

    cap_activity_det #(.SMP_W(SMP_W)) u_act (
        .smp_i (smp_i),
        .vld_i (smp_vld_i),
        .thr_i (thr_i),
        .hit_o (hit)
    );

    cap_seg_buffer #(.SMP_W(SMP_W), .SEG_LEN(SEG_LEN)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (buf_we),
        .waddr_i (buf_waddr),
        .wdata_i (smp_i),
        .raddr_i (buf_raddr_i),
        .rdata_o (buf_rdata_o)
    );

    cap_store_seq #(.SEG_LEN(SEG_LEN), .DEPTH(DEPTH), .RD_LAT(RD_LAT)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (store_start),
        .res_rd_o     (res_rd_o),
        .res_addr_o   (res_addr_o),
        .last_issue_o (last_issue),
        .busy_o       (store_busy),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .wptr_o       (dbg_wptr_o),
        .room_o       (room)
    );

    // Next-state logic for the capture sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (hit) state_d = ST_FILL;
            ST_FILL:  if (smp_vld_i && (fill_idx_q == LAST_IDX)) state_d = ST_TRIG;
            ST_TRIG:  state_d = ST_WAIT;
            ST_WAIT:  if (fft_done_i) state_d = ST_STORE;
            ST_STORE: if (last_issue) state_d = ST_DRAIN;
            ST_DRAIN: if (!store_busy) state_d = room ? ST_IDLE : ST_FULL;
            ST_FULL:  state_d = ST_FULL;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Fill index: the triggering sample takes entry 0, later ones follow in order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_idx_q <= '0;
        end else if ((state_q == ST_IDLE) && hit) begin
            fill_idx_q <= IDX_W'(1);
        end else if ((state_q == ST_FILL) && smp_vld_i) begin
            fill_idx_q <= fill_idx_q + 1'b1;
        end
    end

    // Buffer write steering, handshake and status decode.
    always_comb begin
        buf_we      = ((state_q == ST_IDLE) && hit) || ((state_q == ST_FILL) && smp_vld_i);
        buf_waddr   = (state_q == ST_IDLE) ? '0 : fill_idx_q;
        store_start = (state_q == ST_WAIT) && fft_done_i;
        fft_start_o = (state_q == ST_TRIG);
        full_o      = (state_q == ST_FULL);
        mem_data_o  = res_data_i;
        dbg_state_o = state_q;
    end

    // R2: a qualifying sample in idle opens a segment on the next edge.
    p_open_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && hit) |=> (state_q == ST_FILL));

    // R3: the buffer is written only while idle or filling.
    p_buf_write_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> (state_q == ST_IDLE || state_q == ST_FILL));

    // R4: the start request lasts one cycle.
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fft_start_o |=> !fft_start_o);

    // R5: the wait state holds until the done flag.
    p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !fft_done_i) |=> (state_q == ST_WAIT));

    // R6: bins are read only while in the store state.
    p_read_in_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_rd_o |-> (state_q == ST_STORE));

    // R8: the full state is sticky and performs no writes.
    p_full_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |=> (full_o && !mem_we_o));

    // R9: the debug state code is always a defined encoding.
    p_state_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_state_o <= 3'd6);

endmodule

// File: tb/capture_seq_ctrl_tb_top.sv
module capture_seq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  smp = '0;
    logic        vld = 1'b0;
    logic [7:0]  thr = '0;
    logic [3:0]  buf_raddr = '0;
    logic [7:0]  buf_rdata;
    logic        fft_start;
    logic        fft_done = 1'b0;
    logic        res_rd;
    logic [3:0]  res_addr;
    logic [31:0] res_data;
    logic        mem_we;
    logic [5:0]  mem_addr;
    logic [31:0] mem_data;
    logic        full;
    logic [2:0]  dbg_state;
    logic [6:0]  dbg_wptr;

    int checks = 0;
    int errors = 0;
    int wr_cnt = 0;
    logic [7:0] fft_seg = '0;
    logic [4:0] p1 = '0, p2 = '0;
    logic [7:0] exp_buf [16];

    always #5 clk = ~clk;

    capture_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .smp_vld_i(vld), .thr_i(thr),
        .buf_raddr_i(buf_raddr), .buf_rdata_o(buf_rdata),
        .fft_start_o(fft_start), .fft_done_i(fft_done),
        .res_rd_o(res_rd), .res_addr_o(res_addr), .res_data_i(res_data),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
        .full_o(full), .dbg_state_o(dbg_state), .dbg_wptr_o(dbg_wptr)
    );

    // FFT result port model: two-register read latency, poison data otherwise.
    always @(posedge clk) begin
        p1 <= {res_rd, res_addr};
        p2 <= p1;
    end
    assign res_data = p2[4] ? {8'hC0, fft_seg, 12'h000, p2[3:0]} : 32'hDEAD_BEEF;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Storage memory model: each write must hit the next address with the tagged bin (R6, R7).
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            check(mem_addr == 6'(wr_cnt), "R7", "write address", 32'(mem_addr), 32'(wr_cnt));
            check(mem_data == {8'hC0, 8'(wr_cnt / 16), 12'h000, 4'(wr_cnt % 16)},
                  "R6", "write data", mem_data,
                  {8'hC0, 8'(wr_cnt / 16), 12'h000, 4'(wr_cnt % 16)});
            wr_cnt++;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; vld = 1'b0; fft_done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Table: {thr, smp, vld, expect_open}
    localparam logic [17:0] ACT_TAB [10] = '{
        {8'd10,  8'h0B, 1'b1, 1'b1},
        {8'd10,  8'h0A, 1'b1, 1'b0},
        {8'd10,  8'hF5, 1'b1, 1'b1},
        {8'd10,  8'hF6, 1'b1, 1'b0},
        {8'd127, 8'h80, 1'b1, 1'b1},
        {8'd127, 8'h7F, 1'b1, 1'b0},
        {8'd0,   8'h00, 1'b1, 1'b0},
        {8'd0,   8'hFF, 1'b1, 1'b1},
        {8'd255, 8'h80, 1'b1, 1'b0},
        {8'd0,   8'h40, 1'b0, 1'b0}
    };

    task automatic run_segment(input int seg);
        thr = 8'd20;
        smp = 8'hEC; vld = 1'b1;            // -20: magnitude equal to threshold
        @(negedge clk);
        check(dbg_state == 3'd0, "R2", "equal magnitude keeps idle", 32'(dbg_state), 0);
        exp_buf[0] = 8'(-(21 + seg));
        smp = exp_buf[0];
        @(negedge clk);
        check(dbg_state == 3'd1, "R2", "active sample opens fill", 32'(dbg_state), 1);
        for (int k = 1; k < 16; k++) begin
            if (k % 4 == 0) begin
                smp = 8'h55; vld = 1'b0;    // gap cycle: must not be stored
                @(negedge clk);
            end
            exp_buf[k] = 8'(seg * 16 + k * 5);
            smp = exp_buf[k]; vld = 1'b1;
            @(negedge clk);
        end
        vld = 1'b0;
        check(dbg_state == 3'd2, "R3", "trigger after 16 samples", 32'(dbg_state), 2);
        check(fft_start == 1'b1, "R4", "start asserted", 32'(fft_start), 1);
        @(negedge clk);
        check(dbg_state == 3'd3 && !fft_start, "R4", "single start then wait",
              32'({fft_start, dbg_state}), 3);
        smp = 8'h7F; vld = 1'b1;            // samples during wait are ignored
        repeat (3) @(negedge clk);
        vld = 1'b0;
        check(dbg_state == 3'd3, "R5", "wait holds without done", 32'(dbg_state), 3);
        for (int k = 0; k < 16; k++) begin
            buf_raddr = 4'(k);
            @(negedge clk);
            check(buf_rdata == exp_buf[k], "R3", "buffer entry", 32'(buf_rdata), 32'(exp_buf[k]));
        end
        fft_seg = 8'(seg);
        fft_done = 1'b1;
        @(negedge clk);
        fft_done = 1'b0;
        check(dbg_state == 3'd4, "R5", "done moves to store", 32'(dbg_state), 4);
        for (int n = 0; n < 60; n++) begin
            if (dbg_state == 3'd0 || dbg_state == 3'd6) break;
            @(negedge clk);
        end
        check(wr_cnt == 16 * (seg + 1), "R6", "writes per segment", 32'(wr_cnt), 32'(16 * (seg + 1)));
        check(dbg_wptr == 7'(16 * (seg + 1)), "R9", "debug pointer", 32'(dbg_wptr), 32'(16 * (seg + 1)));
        if (seg < 3) begin
            check(dbg_state == 3'd0 && !full, "R8", "room left returns to idle",
                  32'({full, dbg_state}), 0);
        end else begin
            check(dbg_state == 3'd6 && full, "R8", "no room enters full",
                  32'({full, dbg_state}), 32'h0E);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        @(negedge clk);
        check(dbg_state == 3'd0 && dbg_wptr == 7'd0, "R1", "reset state/pointer",
              32'({dbg_wptr, dbg_state}), 0);
        check(!full && !fft_start && !res_rd && !mem_we, "R1", "reset outputs",
              32'({full, fft_start, res_rd, mem_we}), 0);

        // R2: activity table walk
        for (int i = 0; i < 10; i++) begin
            do_reset();
            thr = ACT_TAB[i][17:10];
            smp = ACT_TAB[i][9:2];
            vld = ACT_TAB[i][1];
            @(negedge clk);
            vld = 1'b0;
            check(dbg_state == (ACT_TAB[i][0] ? 3'd1 : 3'd0), "R2", "activity table",
                  32'(dbg_state), ACT_TAB[i][0] ? 1 : 0);
        end

        // R3..R9: four full segments into 64 storage locations
        do_reset();
        wr_cnt = 0;
        @(negedge clk);
        for (int s = 0; s < 4; s++) run_segment(s);

        // R8: full state ignores further activity
        thr = 8'd5; smp = 8'h9C; vld = 1'b1;
        repeat (5) @(negedge clk);
        vld = 1'b0;
        check(dbg_state == 3'd6 && full, "R8", "full stays full", 32'(dbg_state), 6);
        check(wr_cnt == 64 && dbg_wptr == 7'd64, "R8", "no writes when full", 32'(wr_cnt), 64);

        // R1/R7: only reset clears the pointer
        do_reset();
        @(negedge clk);
        check(dbg_wptr == 7'd0 && dbg_state == 3'd0 && !full, "R7", "reset clears pointer",
              32'({full, dbg_wptr, dbg_state}), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule